// File: doc/BRIEF.md
# AXI response latency and outstanding limiter

This block sits between an AXI master and a memory, on a single ID with in-order responses. It gives the master memory timing that is defined and can be tuned. Address requests are admitted only while the numbers of pending reads, pending writes and their sum stay within programmed caps. Each cap is six bits wide, and zero removes it. Read data and write responses are held back until a programmed minimum number of cycles has elapsed since the request.

Each accepted read is stamped with its due cycle when the address handshake happens. Each write is stamped when its final data beat is accepted. The stamps wait in small in-order queues. A response passes to the master only when two things are true: the free-running cycle count has reached the stamp at the head of the queue, and the memory has produced the response. A response that the memory delivers after its due cycle is forwarded straight away, and a one-cycle lateness pulse is raised for that channel. The queue depth is also reported on a constant output, so software knows the largest cap that has any effect.

Top module: `axi_lat_limiter`

## Requirements
- R1: While the read cap is nonzero and the number of pending reads equals it, `s_arready` and `m_arvalid` stay low. A read cap of 0 imposes no read limit.
- R2: While the write cap is nonzero and the number of pending writes equals it, `s_awready` and `m_awvalid` stay low. A write cap of 0 imposes no write limit.
- R3: While the combined cap is nonzero, pending reads plus pending writes never exceed it. When one slot remains and AR and AW are both requested in the same cycle, the read is admitted and the write waits.
- R4: A read counts as pending from its AR handshake until the handshake of its last R beat (`s_rlast` high). A new read blocked by a cap is admitted in the cycle after that last beat.
- R5: The first R beat of a read is offered to the master no earlier than L cycles after the AR handshake cycle, where L is the 12-bit read latency and a value of 0 acts as 1. If the memory is ready sooner, the beat appears exactly L cycles after the handshake.
- R6: The B response of a write is offered no earlier than L cycles after the cycle in which its final W beat (`s_wlast` high) is accepted, where L is the 12-bit write latency and a value of 0 acts as 1.
- R7: A response that the memory first presents after its due cycle is forwarded in that same cycle. The channel's late output (`rd_late_o` or `wr_late_o`) is then high for exactly one cycle. It stays low for responses that arrive on time.
- R8: A W beat is accepted only while some accepted AW has not yet had its final W beat. Beats driven with no such AW see `s_wready` low.
- R9: `lim_depth_o` equals the DEPTH parameter. Pending reads and pending writes each never exceed DEPTH, even when a cap is larger or zero.
- R10: During and right after reset, `s_rvalid`, `s_bvalid`, `rd_late_o` and `wr_late_o` are low.
- R11: Addresses, lengths, data, `last` flags and the write response code pass through unchanged. The bench memory returns beat k of a read as 0xA0+k and the response code 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rd_cap | input | 6 | Read pending cap, 0 = none |
| cfg_wr_cap | input | 6 | Write pending cap, 0 = none |
| cfg_all_cap | input | 6 | Combined pending cap, 0 = none |
| cfg_rd_lat | input | 12 | Minimum read latency in cycles |
| cfg_wr_lat | input | 12 | Minimum write response latency in cycles |
| lim_depth_o | output | 6 | Largest effective pending count (DEPTH) |
| s_arvalid | input | 1 | Master read address valid |
| s_arready | output | 1 | Master read address ready |
| s_araddr | input | ADDR_W | Master read address |
| s_arlen | input | LEN_W | Master read burst length minus one |
| m_arvalid | output | 1 | Memory read address valid |
| m_arready | input | 1 | Memory read address ready |
| m_araddr | output | ADDR_W | Memory read address |
| m_arlen | output | LEN_W | Memory read burst length minus one |
| m_rvalid | input | 1 | Memory read data valid |
| m_rready | output | 1 | Memory read data ready |
| m_rdata | input | DATA_W | Memory read data |
| m_rlast | input | 1 | Memory last read beat |
| s_rvalid | output | 1 | Master read data valid |
| s_rready | input | 1 | Master read data ready |
| s_rdata | output | DATA_W | Master read data |
| s_rlast | output | 1 | Master last read beat |
| s_awvalid | input | 1 | Master write address valid |
| s_awready | output | 1 | Master write address ready |
| s_awaddr | input | ADDR_W | Master write address |
| s_awlen | input | LEN_W | Master write burst length minus one |
| m_awvalid | output | 1 | Memory write address valid |
| m_awready | input | 1 | Memory write address ready |
| m_awaddr | output | ADDR_W | Memory write address |
| m_awlen | output | LEN_W | Memory write burst length minus one |
| s_wvalid | input | 1 | Master write data valid |
| s_wready | output | 1 | Master write data ready |
| s_wdata | input | DATA_W | Master write data |
| s_wlast | input | 1 | Master last write beat |
| m_wvalid | output | 1 | Memory write data valid |
| m_wready | input | 1 | Memory write data ready |
| m_wdata | output | DATA_W | Memory write data |
| m_wlast | output | 1 | Memory last write beat |
| m_bvalid | input | 1 | Memory write response valid |
| m_bready | output | 1 | Memory write response ready |
| m_bresp | input | 2 | Memory write response code |
| s_bvalid | output | 1 | Master write response valid |
| s_bready | input | 1 | Master write response ready |
| s_bresp | output | 2 | Master write response code |
| rd_late_o | output | 1 | One-cycle pulse: read data arrived after its due cycle |
| wr_late_o | output | 1 | One-cycle pulse: write response arrived after its due cycle |

## Verification
Two things can land on the same cycle: the admission of a read and the admission of a write, both counted against the combined cap. To provoke this, the bench parks two slow reads under a combined cap of three, then raises AR and AW together. It judges the outcome at the ports: AR must be ready and AW must not. AW must then stay blocked until the first read's last beat retires. A second overlap is the due cycle meeting the memory's own delay. The vector table sweeps the memory delay below, equal to and above the programmed latency. For each case it compares the first-beat cycle with the larger of the two, and it expects a lateness pulse only when the memory was the slower of the two.

// File: rtl/lat_lim_pkg.sv
package lat_lim_pkg;
   localparam int CAP_W = 6;
   localparam int LAT_W = 12;

   // A latency of zero cannot be met by a registered stamp: treat it as one.
   function automatic logic [LAT_W-1:0] lat_floor(input logic [LAT_W-1:0] lat);
      return (lat == '0) ? LAT_W'(1) : lat;
   endfunction
endpackage

// File: rtl/lat_stamp_fifo.sv
module lat_stamp_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [W-1:0]     data_i,
   input  logic             pop_i,
   output logic [W-1:0]     data_o,
   output logic [CNT_W-1:0] count_o,
   output logic             full_o,
   output logic             empty_o
);
   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
   end

   assign count_o = count_q;
   assign full_o  = (count_q == CNT_W'(DEPTH));
   assign empty_o = (count_q == '0);

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      slot_q <= '0;
         else if (push_i) slot_q <= data_i;
      end
      assign data_o = slot_q;
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      logic [W-1:0]  mem_q [DEPTH];
      logic [PW-1:0] wp_q, rp_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
         end else begin
            if (push_i) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
            if (pop_i)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
         end
      end

      always_ff @(posedge clk) begin
         if (push_i) mem_q[wp_q] <= data_i;
      end

      assign data_o = mem_q[rp_q];
   end
endmodule

// File: rtl/lat_admit.sv
module lat_admit #(
   parameter int CNT_W = 5,
   parameter int CAP_W = 6
) (
   input  logic [CNT_W-1:0] rd_cnt_i,
   input  logic [CNT_W-1:0] wr_cnt_i,
   input  logic             rd_full_i,
   input  logic             wr_full_i,
   input  logic [CAP_W-1:0] rd_cap_i,
   input  logic [CAP_W-1:0] wr_cap_i,
   input  logic [CAP_W-1:0] all_cap_i,
   input  logic             ar_req_i,
   output logic             rd_ok_o,
   output logic             wr_ok_o
);
   localparam int SUM_W = CNT_W + 1;
   localparam int CMP_W = ((SUM_W > CAP_W) ? SUM_W : CAP_W) + 1;

   logic [CMP_W-1:0] rd_x, wr_x, sum_x, sum_ar_x;
   logic [CMP_W-1:0] rd_cap_x, wr_cap_x, all_cap_x;
   logic             rd_cap_ok, wr_cap_ok, rd_all_ok, wr_all_ok;

   always_comb begin
      rd_x      = CMP_W'(rd_cnt_i);
      wr_x      = CMP_W'(wr_cnt_i);
      sum_x     = rd_x + wr_x;
      rd_cap_x  = CMP_W'(rd_cap_i);
      wr_cap_x  = CMP_W'(wr_cap_i);
      all_cap_x = CMP_W'(all_cap_i);

      rd_cap_ok = (rd_cap_i == '0) || (rd_x < rd_cap_x);
      wr_cap_ok = (wr_cap_i == '0) || (wr_x < wr_cap_x);
      rd_all_ok = (all_cap_i == '0) || (sum_x < all_cap_x);
      rd_ok_o   = !rd_full_i && rd_cap_ok && rd_all_ok;

      // a read asking in the same cycle takes the last combined slot first
      sum_ar_x  = sum_x + CMP_W'(ar_req_i && rd_ok_o);
      wr_all_ok = (all_cap_i == '0) || (sum_ar_x < all_cap_x);
      wr_ok_o   = !wr_full_i && wr_cap_ok && wr_all_ok;
   end
endmodule

// File: rtl/lat_resp_gate.sv
module lat_resp_gate #(
   parameter int TS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TS_W-1:0] now_i,
   input  logic            head_vld_i,
   input  logic [TS_W-1:0] head_due_i,
   input  logic            m_valid_i,
   input  logic            m_last_i,
   input  logic            s_ready_i,
   output logic            s_valid_o,
   output logic            m_ready_o,
   output logic            done_o,
   output logic            late_o
);
   logic [TS_W-1:0] slack;
   logic            reached, open, first_show;
   logic            opened_q, seen_q;

   assign slack      = now_i - head_due_i;
   assign reached    = !slack[TS_W-1];
   assign open       = head_vld_i && (opened_q || reached);
   assign s_valid_o  = m_valid_i && open;
   assign m_ready_o  = s_ready_i && open;
   assign done_o     = s_valid_o && s_ready_i && m_last_i;
   assign first_show = open && m_valid_i && !seen_q;
   assign late_o     = first_show && (slack != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opened_q <= 1'b0;
         seen_q   <= 1'b0;
      end else if (done_o) begin
         opened_q <= 1'b0;
         seen_q   <= 1'b0;
      end else begin
         if (open)       opened_q <= 1'b1;
         if (first_show) seen_q   <= 1'b1;
      end
   end
endmodule

// File: rtl/axi_lat_limiter.sv
module axi_lat_limiter
   import lat_lim_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 8,
   parameter int DEPTH  = 16,
   parameter int TS_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [5:0]        cfg_rd_cap,
   input  logic [5:0]        cfg_wr_cap,
   input  logic [5:0]        cfg_all_cap,
   input  logic [11:0]       cfg_rd_lat,
   input  logic [11:0]       cfg_wr_lat,
   output logic [5:0]        lim_depth_o,
   input  logic              s_arvalid,
   output logic              s_arready,
   input  logic [ADDR_W-1:0] s_araddr,
   input  logic [LEN_W-1:0]  s_arlen,
   output logic              m_arvalid,
   input  logic              m_arready,
   output logic [ADDR_W-1:0] m_araddr,
   output logic [LEN_W-1:0]  m_arlen,
   input  logic              m_rvalid,
   output logic              m_rready,
   input  logic [DATA_W-1:0] m_rdata,
   input  logic              m_rlast,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic [DATA_W-1:0] s_rdata,
   output logic              s_rlast,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic [LEN_W-1:0]  s_awlen,
   output logic              m_awvalid,
   input  logic              m_awready,
   output logic [ADDR_W-1:0] m_awaddr,
   output logic [LEN_W-1:0]  m_awlen,
   input  logic              s_wvalid,
   output logic              s_wready,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic              s_wlast,
   output logic              m_wvalid,
   input  logic              m_wready,
   output logic [DATA_W-1:0] m_wdata,
   output logic              m_wlast,
   input  logic              m_bvalid,
   output logic              m_bready,
   input  logic [1:0]        m_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   output logic [1:0]        s_bresp,
   output logic              rd_late_o,
   output logic              wr_late_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int MAX_DEPTH = (1 << CAP_W) - 1;

   if (DEPTH < 1 || DEPTH > MAX_DEPTH) begin : g_bad_depth
      $error("DEPTH must lie between 1 and the largest cap value");
   end
   if (TS_W < LAT_W + 2) begin : g_bad_ts
      $error("TS_W must exceed the latency width by at least two bits");
   end
   if (LEN_W < 1 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("bus widths must be positive");
   end

   // ---------------- time base ----------------
   logic [TS_W-1:0] now_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now_q <= '0;
      else        now_q <= now_q + TS_W'(1);
   end

   logic [TS_W-1:0] rd_due, wr_due;
   assign rd_due = now_q + TS_W'(lat_floor(cfg_rd_lat));
   assign wr_due = now_q + TS_W'(lat_floor(cfg_wr_lat));

   assign lim_depth_o = CAP_W'(DEPTH);

   // ---------------- bookkeeping of pending work ----------------
   logic             ar_hs, aw_hs, wl_hs, b_hs;
   logic             rd_ok, wr_ok, w_ok;
   logic             rd_done, wr_done;
   logic [CNT_W-1:0] rd_cnt, wq_cnt;
   logic [CNT_W-1:0] wr_cnt_q;
   logic             rd_full, rd_empty, wq_full, wq_empty;
   logic [TS_W-1:0]  rd_head_due, wr_head_due;

   assign ar_hs = s_arvalid && s_arready;
   assign aw_hs = s_awvalid && s_awready;
   assign wl_hs = s_wvalid && s_wready && s_wlast;
   assign b_hs  = s_bvalid && s_bready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_cnt_q <= '0;
      else        wr_cnt_q <= wr_cnt_q + CNT_W'(aw_hs) - CNT_W'(b_hs);
   end

   lat_stamp_fifo #(.DEPTH(DEPTH), .W(TS_W), .CNT_W(CNT_W)) u_rd_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (ar_hs),
      .data_i  (rd_due),
      .pop_i   (rd_done),
      .data_o  (rd_head_due),
      .count_o (rd_cnt),
      .full_o  (rd_full),
      .empty_o (rd_empty)
   );

   lat_stamp_fifo #(.DEPTH(DEPTH), .W(TS_W), .CNT_W(CNT_W)) u_wr_q (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (wl_hs),
      .data_i  (wr_due),
      .pop_i   (wr_done),
      .data_o  (wr_head_due),
      .count_o (wq_cnt),
      .full_o  (wq_full),
      .empty_o (wq_empty)
   );

   lat_admit #(.CNT_W(CNT_W), .CAP_W(CAP_W)) u_admit (
      .rd_cnt_i  (rd_cnt),
      .wr_cnt_i  (wr_cnt_q),
      .rd_full_i (rd_full),
      .wr_full_i (wr_cnt_q == CNT_W'(DEPTH)),
      .rd_cap_i  (cfg_rd_cap),
      .wr_cap_i  (cfg_wr_cap),
      .all_cap_i (cfg_all_cap),
      .ar_req_i  (s_arvalid),
      .rd_ok_o   (rd_ok),
      .wr_ok_o   (wr_ok)
   );

   // a W burst may only follow an AW whose last beat is still missing
   assign w_ok = (wq_cnt < wr_cnt_q) && !wq_full;

   // ---------------- request channels ----------------
   assign m_arvalid = s_arvalid && rd_ok;
   assign s_arready = m_arready && rd_ok;
   assign m_araddr  = s_araddr;
   assign m_arlen   = s_arlen;

   assign m_awvalid = s_awvalid && wr_ok;
   assign s_awready = m_awready && wr_ok;
   assign m_awaddr  = s_awaddr;
   assign m_awlen   = s_awlen;

   assign m_wvalid  = s_wvalid && w_ok;
   assign s_wready  = m_wready && w_ok;
   assign m_wdata   = s_wdata;
   assign m_wlast   = s_wlast;

   // ---------------- response channels ----------------
   lat_resp_gate #(.TS_W(TS_W)) u_r_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .now_i      (now_q),
      .head_vld_i (!rd_empty),
      .head_due_i (rd_head_due),
      .m_valid_i  (m_rvalid),
      .m_last_i   (m_rlast),
      .s_ready_i  (s_rready),
      .s_valid_o  (s_rvalid),
      .m_ready_o  (m_rready),
      .done_o     (rd_done),
      .late_o     (rd_late_o)
   );
   assign s_rdata = m_rdata;
   assign s_rlast = m_rlast;

   lat_resp_gate #(.TS_W(TS_W)) u_b_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .now_i      (now_q),
      .head_vld_i (!wq_empty),
      .head_due_i (wr_head_due),
      .m_valid_i  (m_bvalid),
      .m_last_i   (1'b1),
      .s_ready_i  (s_bready),
      .s_valid_o  (s_bvalid),
      .m_ready_o  (m_bready),
      .done_o     (wr_done),
      .late_o     (wr_late_o)
   );
   assign s_bresp = m_bresp;
endmodule

// File: rtl/axi_lat_limiter_chk.sv
module axi_lat_limiter_chk #(
   parameter int DEPTH = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic [5:0] cfg_rd_cap,
   input logic [5:0] cfg_wr_cap,
   input logic [5:0] cfg_all_cap,
   input logic       s_arvalid,
   input logic       s_arready,
   input logic       s_rvalid,
   input logic       s_rready,
   input logic       s_rlast,
   input logic       s_awvalid,
   input logic       s_awready,
   input logic       s_wvalid,
   input logic       s_wready,
   input logic       s_wlast,
   input logic       s_bvalid,
   input logic       s_bready,
   input logic       rd_late_o,
   input logic       wr_late_o
);
   logic       ar_hs, aw_hs, rl_hs, wl_hs, b_hs;
   logic [7:0] rd_pend, wr_pend, wl_pend;

   assign ar_hs = s_arvalid && s_arready;
   assign aw_hs = s_awvalid && s_awready;
   assign rl_hs = s_rvalid && s_rready && s_rlast;
   assign wl_hs = s_wvalid && s_wready && s_wlast;
   assign b_hs  = s_bvalid && s_bready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= '0;
         wr_pend <= '0;
         wl_pend <= '0;
      end else begin
         rd_pend <= rd_pend + 8'(ar_hs) - 8'(rl_hs);
         wr_pend <= wr_pend + 8'(aw_hs) - 8'(b_hs);
         wl_pend <= wl_pend + 8'(wl_hs) - 8'(b_hs);
      end
   end

   p_rd_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ar_hs |-> (cfg_rd_cap == 6'd0 || rd_pend < 8'(cfg_rd_cap)));

   p_wr_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      aw_hs |-> (cfg_wr_cap == 6'd0 || wr_pend < 8'(cfg_wr_cap)));

   p_all_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_hs || aw_hs) |->
         (cfg_all_cap == 6'd0 ||
          rd_pend + wr_pend + 8'(ar_hs) + 8'(aw_hs) <= 8'(cfg_all_cap)));

   p_w_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s_wvalid && s_wready) |-> (wl_pend < wr_pend));

   p_depth_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_hs || aw_hs) |-> (rd_pend <= 8'(DEPTH) && wr_pend <= 8'(DEPTH)));

   p_rd_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_late_o |-> (s_rvalid && rd_pend != 8'd0));

   p_wr_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_late_o |-> (s_bvalid && wl_pend != 8'd0));

   p_late_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_late_o && !(s_rready && s_rlast)) |=> !rd_late_o);
endmodule

bind axi_lat_limiter axi_lat_limiter_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_rd_cap  (cfg_rd_cap),
   .cfg_wr_cap  (cfg_wr_cap),
   .cfg_all_cap (cfg_all_cap),
   .s_arvalid   (s_arvalid),
   .s_arready   (s_arready),
   .s_rvalid    (s_rvalid),
   .s_rready    (s_rready),
   .s_rlast     (s_rlast),
   .s_awvalid   (s_awvalid),
   .s_awready   (s_awready),
   .s_wvalid    (s_wvalid),
   .s_wready    (s_wready),
   .s_wlast     (s_wlast),
   .s_bvalid    (s_bvalid),
   .s_bready    (s_bready),
   .rd_late_o   (rd_late_o),
   .wr_late_o   (wr_late_o)
);

// File: tb/axi_lat_limiter_tb_top.sv
`timescale 1ns/100ps
module axi_lat_limiter_tb_top;
   localparam int DEPTH = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [5:0]  cfg_rd_cap = '0, cfg_wr_cap = '0, cfg_all_cap = '0;
   logic [11:0] cfg_rd_lat = 12'd1, cfg_wr_lat = 12'd1;
   logic [5:0]  lim_depth_o;
   logic        s_arvalid = 0, s_arready, m_arvalid, m_arready;
   logic [31:0] s_araddr = '0, m_araddr;
   logic [7:0]  s_arlen = '0, m_arlen;
   logic        m_rvalid, m_rready, m_rlast, s_rvalid, s_rlast;
   logic        s_rready = 1'b1;
   logic [31:0] m_rdata, s_rdata;
   logic        s_awvalid = 0, s_awready, m_awvalid, m_awready;
   logic [31:0] s_awaddr = '0, m_awaddr;
   logic [7:0]  s_awlen = '0, m_awlen;
   logic        s_wvalid = 0, s_wready, s_wlast = 0, m_wvalid, m_wready, m_wlast;
   logic [31:0] s_wdata = '0, m_wdata;
   logic        m_bvalid, m_bready, s_bvalid;
   logic        s_bready = 1'b1;
   logic [1:0]  m_bresp, s_bresp;
   logic        rd_late_o, wr_late_o;

   axi_lat_limiter #(.DEPTH(DEPTH)) dut_i (.*);

   // ---------------- cycle count and memory responder ----------------
   int cyc = 0;
   int memd = 1;
   always @(posedge clk) cyc <= cyc + 1;

   int         rq_t [64];
   logic [7:0] rq_len [64];
   logic [5:0] rq_wp = '0, rq_rp = '0;
   logic [7:0] beat = '0;
   int         bq_t [64];
   logic [5:0] bq_wp = '0, bq_rp = '0;

   assign m_arready = 1'b1;
   assign m_awready = 1'b1;
   assign m_wready  = 1'b1;
   assign m_bresp   = 2'b01;

   always_comb begin
      m_rvalid = (rq_wp != rq_rp) && ((cyc - rq_t[rq_rp]) >= memd);
      m_rlast  = (beat == rq_len[rq_rp]);
      m_rdata  = 32'hA0 + 32'(beat);
      m_bvalid = (bq_wp != bq_rp) && ((cyc - bq_t[bq_rp]) >= memd);
   end

   always @(posedge clk) begin
      if (m_arvalid && m_arready) begin
         rq_t[rq_wp]   <= cyc;
         rq_len[rq_wp] <= m_arlen;
         rq_wp         <= rq_wp + 6'd1;
      end
      if (m_rvalid && m_rready) begin
         if (m_rlast) begin
            beat  <= '0;
            rq_rp <= rq_rp + 6'd1;
         end else beat <= beat + 8'd1;
      end
      if (m_wvalid && m_wready && m_wlast) begin
         bq_t[bq_wp] <= cyc;
         bq_wp       <= bq_wp + 6'd1;
      end
      if (m_bvalid && m_bready) bq_rp <= bq_rp + 6'd1;
   end

   // ---------------- monitor ----------------
   int t_ar = 0, r_first = -1, r_late = 0, r_done = 0, r_beats = 0, r_beats_last = 0, t_rlast = 0;
   int t_w = 0, b_first = -1, b_late = 0, b_done = 0;
   logic [31:0] r_data0 = '0;
   logic [1:0]  b_resp_last = '0;

   always begin
      @(negedge clk); #1;
      if (s_arvalid && s_arready) begin t_ar = cyc; r_first = -1; end
      if (s_rvalid && r_first < 0) begin r_first = cyc; r_data0 = s_rdata; end
      if (rd_late_o) r_late++;
      if (s_rvalid && s_rready) begin
         r_beats++;
         if (s_rlast) begin r_beats_last = r_beats; r_beats = 0; r_done++; t_rlast = cyc; end
      end
      if (s_wvalid && s_wready && s_wlast) begin t_w = cyc; b_first = -1; end
      if (s_bvalid && b_first < 0) b_first = cyc;
      if (wr_late_o) b_late++;
      if (s_bvalid && s_bready) begin b_done++; b_resp_last = s_bresp; end
   end

   // ---------------- checking ----------------
   int total = 0, bad = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (cyc > 150000) begin
         bad++;
         $display("FAIL R10 watchdog: actual=%0d expected=<150000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic do_ar(input logic [7:0] len, output bit first);
      @(negedge clk);
      s_arvalid = 1'b1; s_arlen = len; s_araddr = s_araddr + 32'h40;
      #1; first = s_arready;
      while (!s_arready) begin @(negedge clk); #1; end
      @(negedge clk);
      s_arvalid = 1'b0;
   endtask

   task automatic do_aw(input logic [7:0] len, output bit first);
      @(negedge clk);
      s_awvalid = 1'b1; s_awlen = len; s_awaddr = s_awaddr + 32'h40;
      #1; first = s_awready;
      while (!s_awready) begin @(negedge clk); #1; end
      @(negedge clk);
      s_awvalid = 1'b0;
   endtask

   // called at a negedge; leaves at the negedge after the last beat
   task automatic do_w(input logic [7:0] len);
      for (int k = 0; k <= int'(len); k++) begin
         s_wvalid = 1'b1; s_wlast = (k == int'(len)); s_wdata = 32'(k);
         #1;
         while (!s_wready) begin @(negedge clk); #1; end
         @(negedge clk);
      end
      s_wvalid = 1'b0; s_wlast = 1'b0;
   endtask

   task automatic wait_rd(input int n);
      while (r_done < n) @(negedge clk);
   endtask

   task automatic wait_b(input int n);
      while (b_done < n) @(negedge clk);
   endtask

   // {rd_lat, wr_lat, mem delay, len, exp rd cycles, exp wr cycles, rd late, wr late}
   localparam logic [61:0] VEC [7] = '{
      {12'd5,    12'd7,  8'd1,  4'd0, 12'd5,    12'd7,  1'b0, 1'b0},
      {12'd0,    12'd0,  8'd1,  4'd0, 12'd1,    12'd1,  1'b0, 1'b0},
      {12'd3,    12'd2,  8'd8,  4'd2, 12'd8,    12'd8,  1'b1, 1'b1},
      {12'd12,   12'd1,  8'd12, 4'd1, 12'd12,   12'd12, 1'b0, 1'b1},
      {12'd40,   12'd20, 8'd3,  4'd3, 12'd40,   12'd20, 1'b0, 1'b0},
      {12'd1,    12'd9,  8'd2,  4'd0, 12'd2,    12'd9,  1'b1, 1'b0},
      {12'd4095, 12'd0,  8'd1,  4'd0, 12'd4095, 12'd1,  1'b0, 1'b0}
   };

   initial begin
      bit f;
      int n0;
      // reset state (R10, R9)
      repeat (3) @(negedge clk);
      chk(!s_rvalid && !s_bvalid, "R10", "valids in reset", int'(s_rvalid) + int'(s_bvalid), 0);
      chk(!rd_late_o && !wr_late_o, "R10", "late in reset", int'(rd_late_o) + int'(wr_late_o), 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!s_rvalid && !s_bvalid, "R10", "valids after reset", int'(s_rvalid) + int'(s_bvalid), 0);
      chk(lim_depth_o == 6'(DEPTH), "R9", "depth report", int'(lim_depth_o), DEPTH);

      // W with no AW pending (R8)
      @(negedge clk);
      s_wvalid = 1'b1; s_wlast = 1'b1; #1;
      chk(!s_wready, "R8", "wready without AW", int'(s_wready), 0);
      @(negedge clk);
      s_wvalid = 1'b0; s_wlast = 1'b0;

      // latency vector table (R5, R6, R7, R11)
      foreach (VEC[i]) begin
         cfg_rd_lat = VEC[i][61:50];
         cfg_wr_lat = VEC[i][49:38];
         memd       = int'(VEC[i][37:30]);
         n0 = r_done;
         do_ar(8'(VEC[i][29:26]), f);
         n0 = r_late;
         wait_rd(r_done + 1);
         repeat (2) @(negedge clk);
         chk(r_first - t_ar == int'(VEC[i][25:14]), "R5", $sformatf("vec%0d rd latency", i), r_first - t_ar, int'(VEC[i][25:14]));
         chk(r_late - n0 == int'(VEC[i][1]), "R7", $sformatf("vec%0d rd late pulses", i), r_late - n0, int'(VEC[i][1]));
         chk(r_data0 == 32'hA0 && r_beats_last == int'(VEC[i][29:26]) + 1, "R11",
             $sformatf("vec%0d rd data/beats", i), r_beats_last, int'(VEC[i][29:26]) + 1);
         n0 = b_late;
         do_aw(8'(VEC[i][29:26]), f);
         do_w(8'(VEC[i][29:26]));
         wait_b(b_done + 1);
         repeat (2) @(negedge clk);
         chk(b_first - t_w == int'(VEC[i][13:2]), "R6", $sformatf("vec%0d wr latency", i), b_first - t_w, int'(VEC[i][13:2]));
         chk(b_late - n0 == int'(VEC[i][0]), "R7", $sformatf("vec%0d wr late pulses", i), b_late - n0, int'(VEC[i][0]));
         chk(b_resp_last == 2'b01, "R11", $sformatf("vec%0d bresp", i), int'(b_resp_last), 1);
      end

      // read cap 1, burst of 4: pending until RLAST (R1, R4)
      cfg_rd_lat = 12'd1; cfg_wr_lat = 12'd1; memd = 10;
      cfg_rd_cap = 6'd1;
      n0 = r_done;
      do_ar(8'd3, f);
      @(negedge clk);
      s_arvalid = 1'b1; s_arlen = 8'd0; #1;
      chk(!s_arready && !m_arvalid, "R1", "AR blocked at read cap", int'(s_arready), 0);
      while (!s_arready) begin @(negedge clk); #1; end
      chk(r_done == n0 + 1, "R4", "second AR after RLAST", r_done - n0, 1);
      chk(cyc == t_rlast + 1, "R4", "admit cycle after last beat", cyc - t_rlast, 1);
      @(negedge clk); s_arvalid = 1'b0;
      wait_rd(n0 + 2);

      // write cap 1 (R2)
      cfg_rd_cap = 6'd0; cfg_wr_cap = 6'd1; memd = 20;
      n0 = b_done;
      do_aw(8'd0, f);
      do_w(8'd0);
      s_awvalid = 1'b1; s_awlen = 8'd0; #1;
      chk(!s_awready && !m_awvalid, "R2", "AW blocked at write cap", int'(s_awready), 0);
      while (!s_awready) begin @(negedge clk); #1; end
      chk(b_done == n0 + 1, "R2", "AW admitted after B", b_done - n0, 1);
      @(negedge clk); s_awvalid = 1'b0;
      do_w(8'd0);
      wait_b(n0 + 2);

      // combined cap 3, AR and AW in the same cycle (R3)
      cfg_wr_cap = 6'd0; cfg_all_cap = 6'd3; memd = 60;
      n0 = r_done;
      do_ar(8'd0, f);
      do_ar(8'd0, f);
      s_arvalid = 1'b1; s_awvalid = 1'b1; s_arlen = 8'd0; s_awlen = 8'd0; #1;
      chk(s_arready && !s_awready, "R3", "read wins last slot",
          int'({s_arready, s_awready}), 2);
      @(negedge clk);
      s_arvalid = 1'b0; #1;
      chk(!s_awready, "R3", "AW still blocked at combined cap", int'(s_awready), 0);
      while (!s_awready) begin @(negedge clk); #1; end
      chk(r_done >= n0 + 1, "R3", "AW admitted after a read retired", r_done - n0, 1);
      @(negedge clk); s_awvalid = 1'b0;
      do_w(8'd0);
      wait_rd(n0 + 3);
      wait_b(b_done + 1);

      // zero caps: unlimited up to DEPTH, then blocked (R1, R9)
      cfg_all_cap = 6'd0; memd = 100;
      n0 = r_done;
      for (int k = 0; k < DEPTH; k++) begin
         do_ar(8'd0, f);
         chk(f, "R1", $sformatf("read %0d admitted with cap 0", k), int'(f), 1);
      end
      s_arvalid = 1'b1; #1;
      chk(!s_arready, "R9", "read beyond DEPTH blocked", int'(s_arready), 0);
      @(negedge clk); s_arvalid = 1'b0;
      wait_rd(n0 + DEPTH);
      repeat (3) @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule